// File: doc/BRIEF.md
# Rotating Register Renaming Unit

This block turns logical register numbers into physical register numbers for three register classes (general, floating-point and predicate). In each class, the upper part of the file is a rotating window. A per-class offset steps downward by one on each rotate request. Because of this, a value written under logical number X is later read under logical number X+1. The value that sat at the top of the window comes back at its bottom. Registers below the window always map to themselves.

The general class lets the window size be programmed at run time in groups of eight. Programming the size also clears that class's offset. The floating-point and predicate windows have a fixed size. Each class has a small physical register file behind its mapping, with one write port and two read ports. This lets the renaming be observed directly as values that appear to move. Reads are combinational and use the offset in effect now. A write lands at the edge and uses the mapping that was in effect before any rotation in the same cycle.

Top module: `rot_rename_unit`

## Requirements
- R1: After a synchronous active-low reset, every class offset is 0, the general window size is 0 and every stored value reads 0. Every logical number then maps to itself.
- R2: For a logical number L inside a window with base B, size S and offset K, the physical number is B + ((L - B + K) mod S). The window is B <= L < B+S.
- R3: A rotate request moves the offset from K to K-1, and from 0 to S-1. A value written at logical L reads at L+1 after one rotation and at L+2 after two (35 becomes 37).
- R4: After one rotation, the value held at the highest logical number of a window reads at the window's lowest logical number.
- R5: The general window starts at logical 32. Its size is 8*g, where g is the 4-bit group field. A value of g above 12 is treated as 12 (96 registers).
- R6: Writing the general size clears the general offset to 0. This takes priority over a rotate request in the same cycle.
- R7: With a general size of 0, rotate requests have no effect and the general mapping is the identity.
- R8: The floating-point window covers logical 32..127 (96 registers) and the predicate window covers 16..63 (48). Each class keeps its own offset, and rotating one class does not change the mapping of another.
- R9: A write issued in the same cycle as a rotate of its class goes to the physical register that the pre-rotation mapping selects.
- R10: Read data is combinational. A write becomes visible on the next cycle, so a same-cycle read of the written address returns the old value.
- R11: Logical numbers below a window's base (general and floating-point 0..31, predicate 0..15) never move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gr_rot | input | 1 | Rotate the general class |
| gr_size_we | input | 1 | Load a new general window size |
| gr_size_grp | input | 4 | General window size in groups of eight |
| gr_we | input | 1 | General write enable |
| gr_waddr | input | 7 | General write logical number |
| gr_wdata | input | DATA_W | General write data |
| gr_raddr0 | input | 7 | General read port 0 logical number |
| gr_raddr1 | input | 7 | General read port 1 logical number |
| gr_rdata0 | output | DATA_W | General read port 0 data |
| gr_rdata1 | output | DATA_W | General read port 1 data |
| gr_rphys0 | output | 7 | General read port 0 physical number |
| gr_rphys1 | output | 7 | General read port 1 physical number |
| fr_rot | input | 1 | Rotate the floating-point class |
| fr_we | input | 1 | Floating-point write enable |
| fr_waddr | input | 7 | Floating-point write logical number |
| fr_wdata | input | DATA_W | Floating-point write data |
| fr_raddr0 | input | 7 | Floating-point read port 0 logical number |
| fr_raddr1 | input | 7 | Floating-point read port 1 logical number |
| fr_rdata0 | output | DATA_W | Floating-point read port 0 data |
| fr_rdata1 | output | DATA_W | Floating-point read port 1 data |
| fr_rphys0 | output | 7 | Floating-point read port 0 physical number |
| fr_rphys1 | output | 7 | Floating-point read port 1 physical number |
| pr_rot | input | 1 | Rotate the predicate class |
| pr_we | input | 1 | Predicate write enable |
| pr_waddr | input | 6 | Predicate write logical number |
| pr_wdata | input | 1 | Predicate write value |
| pr_raddr0 | input | 6 | Predicate read port 0 logical number |
| pr_raddr1 | input | 6 | Predicate read port 1 logical number |
| pr_rdata0 | output | 1 | Predicate read port 0 value |
| pr_rdata1 | output | 1 | Predicate read port 1 value |
| pr_rphys0 | output | 6 | Predicate read port 0 physical number |
| pr_rphys1 | output | 6 | Predicate read port 1 physical number |

## Verification
Two pairs of functions can meet in one cycle: a write with a rotate of the same class, and a size load with a rotate. The bench raises both strobes together in a single cycle. It judges the write by reading the value back one logical number higher after the edge; a landing under the post-rotation mapping would leave that read at zero. It judges the size load by the physical number shown for logical 32, which must equal 32 (offset cleared) rather than the number a decremented offset would give.

// File: rtl/rot_pkg.sv
// Shared geometry of the three rotating register classes.
// Assumes the rotating window always ends at the top of its file.
package rot_pkg;
    localparam int GRAN      = 8;    // size granule of the general window
    localparam int GRP_W     = 4;    // width of the size-in-groups field
    localparam int GR_REGS   = 128;
    localparam int GR_BASE   = 32;
    localparam int GR_MAX    = 96;
    localparam int FR_REGS   = 128;
    localparam int FR_BASE   = 32;
    localparam int FR_MAX    = 96;
    localparam int PR_REGS   = 64;
    localparam int PR_BASE   = 16;
    localparam int PR_MAX    = 48;
endpackage

// File: rtl/rot_base_ctr.sv
// Rotation offset and window size for one register class.
// The offset is held modulo the window size and steps down on each rotate.
// When PROG is set the size is loadable in granules; loading also clears
// the offset. Assumes RST_SIZE <= MAX_ROT.
module rot_base_ctr #(
    parameter int MAX_ROT  = 96,
    parameter int GRAN     = 8,
    parameter int GRP_W    = 4,
    parameter int RST_SIZE = 0,
    parameter bit PROG     = 1'b1,
    localparam int SZ_W    = $clog2(MAX_ROT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rot_i,
    input  logic             size_we_i,
    input  logic [GRP_W-1:0] size_grp_i,
    output logic [SZ_W-1:0]  ofs_o,
    output logic [SZ_W-1:0]  size_o
);
    localparam int MAX_GRP = MAX_ROT / GRAN;

    logic [SZ_W-1:0]  ofs_q;
    logic [SZ_W-1:0]  size_q;
    logic [GRP_W-1:0] grp_sat;
    logic [SZ_W-1:0]  size_new;
    logic             load;

    // Saturate the requested group count and scale it to registers.
    always_comb begin
        grp_sat  = (int'(size_grp_i) > MAX_GRP) ? GRP_W'(MAX_GRP) : size_grp_i;
        size_new = SZ_W'(int'(grp_sat) * GRAN);
        load     = PROG && size_we_i;
    end

    // Window size register: loadable only in the programmable variant.
    always_ff @(posedge clk) begin
        if (!rst_n)    size_q <= SZ_W'(RST_SIZE);
        else if (load) size_q <= size_new;
    end

    // Offset register: cleared by a size load, else steps down modulo size.
    always_ff @(posedge clk) begin
        if (!rst_n)                         ofs_q <= '0;
        else if (load)                      ofs_q <= '0;
        else if (rot_i && size_q != '0)     ofs_q <= (ofs_q == '0) ? size_q - SZ_W'(1)
                                                                   : ofs_q - SZ_W'(1);
    end

    assign ofs_o  = ofs_q;
    assign size_o = size_q;

    // R3
    ofs_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (size_q == '0) ? (ofs_q == '0) : (ofs_q < size_q));

    // R3
    ofs_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rot_i && !load && size_q != '0) |=>
        ((ofs_q + SZ_W'(1) == $past(ofs_q)) ||
         ($past(ofs_q) == '0 && ofs_q == $past(size_q) - SZ_W'(1))));

    // R6
    size_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (ofs_q == '0));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rot_i && !size_we_i) |=> $stable(ofs_q));
endmodule

// File: rtl/rot_map.sv
// Logical-to-physical number translation for one port of one class.
// Numbers inside [ROT_BASE, ROT_BASE+size) are offset modulo size;
// all others pass through unchanged. Purely combinational.
module rot_map #(
    parameter int ADDR_W   = 7,
    parameter int ROT_BASE = 32,
    parameter int SZ_W     = 7
) (
    input  logic [ADDR_W-1:0] logical_i,
    input  logic [SZ_W-1:0]   ofs_i,
    input  logic [SZ_W-1:0]   size_i,
    output logic [ADDR_W-1:0] phys_o
);
    localparam int EW = ((ADDR_W > SZ_W) ? ADDR_W : SZ_W) + 1;

    logic [EW-1:0] lg;
    logic [EW-1:0] rel;
    logic [EW-1:0] sum;
    logic [EW-1:0] wrapped;
    logic          in_rot;

    // Window test, offset add and single conditional wrap.
    always_comb begin
        lg      = EW'(logical_i);
        rel     = lg - EW'(ROT_BASE);
        in_rot  = (lg >= EW'(ROT_BASE)) && (rel < EW'(size_i));
        sum     = rel + EW'(ofs_i);
        wrapped = (sum >= EW'(size_i)) ? sum - EW'(size_i) : sum;
        phys_o  = in_rot ? ADDR_W'(wrapped + EW'(ROT_BASE)) : logical_i;
    end

    // Translation stays inside its region.
    always_comb begin
        // R11
        if (lg < EW'(ROT_BASE)) low_fixed_chk: assert (phys_o == logical_i);
        // R2
        if (in_rot) in_window_chk: assert ((EW'(phys_o) >= EW'(ROT_BASE)) &&
                                           (EW'(phys_o) - EW'(ROT_BASE) < EW'(size_i)));
    end
endmodule

// File: rtl/rot_regfile.sv
// Physical storage for one class: one write port, NRD combinational reads.
// Contents clear on reset. Assumes NUM equals 2**ADDR_W.
module rot_regfile #(
    parameter int NUM    = 128,
    parameter int ADDR_W = 7,
    parameter int DATA_W = 16,
    parameter int NRD    = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we_i,
    input  logic [ADDR_W-1:0]            waddr_i,
    input  logic [DATA_W-1:0]            wdata_i,
    input  logic [NRD-1:0][ADDR_W-1:0]   raddr_i,
    output logic [NRD-1:0][DATA_W-1:0]   rdata_o
);
    logic [DATA_W-1:0] mem_q [NUM];

    // Clear on reset, otherwise store the write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM; i++) mem_q[i] <= '0;
        end else if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    // Combinational read ports.
    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata_o[p] = mem_q[raddr_i[p]];
    end

    // R10
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (mem_q[$past(waddr_i)] == $past(wdata_i)));
endmodule

// File: rtl/rot_class.sv
// One register class: offset counter, per-port translators and storage.
// The write translator sees the offset before any same-cycle rotation.
module rot_class #(
    parameter int NUM      = 128,
    parameter int BASE     = 32,
    parameter int MAX_ROT  = 96,
    parameter int RST_SIZE = 0,
    parameter bit PROG     = 1'b1,
    parameter int DATA_W   = 16,
    parameter int GRAN     = 8,
    parameter int GRP_W    = 4,
    localparam int ADDR_W  = $clog2(NUM),
    localparam int NRD     = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rot_i,
    input  logic                        size_we_i,
    input  logic [GRP_W-1:0]            size_grp_i,
    input  logic                        we_i,
    input  logic [ADDR_W-1:0]           waddr_i,
    input  logic [DATA_W-1:0]           wdata_i,
    input  logic [NRD-1:0][ADDR_W-1:0]  raddr_i,
    output logic [NRD-1:0][DATA_W-1:0]  rdata_o,
    output logic [NRD-1:0][ADDR_W-1:0]  rphys_o
);
    localparam int SZ_W = $clog2(MAX_ROT + 1);

    logic [SZ_W-1:0]              ofs;
    logic [SZ_W-1:0]              size;
    logic [ADDR_W-1:0]            wphys;
    logic [NRD-1:0][ADDR_W-1:0]   rphys;

    rot_base_ctr #(
        .MAX_ROT(MAX_ROT), .GRAN(GRAN), .GRP_W(GRP_W),
        .RST_SIZE(RST_SIZE), .PROG(PROG)
    ) u_ctr (
        .clk(clk), .rst_n(rst_n), .rot_i(rot_i),
        .size_we_i(size_we_i), .size_grp_i(size_grp_i),
        .ofs_o(ofs), .size_o(size)
    );

    rot_map #(.ADDR_W(ADDR_W), .ROT_BASE(BASE), .SZ_W(SZ_W)) u_wmap (
        .logical_i(waddr_i), .ofs_i(ofs), .size_i(size), .phys_o(wphys)
    );

    for (genvar p = 0; p < NRD; p++) begin : g_rmap
        rot_map #(.ADDR_W(ADDR_W), .ROT_BASE(BASE), .SZ_W(SZ_W)) u_rmap (
            .logical_i(raddr_i[p]), .ofs_i(ofs), .size_i(size), .phys_o(rphys[p])
        );
    end

    rot_regfile #(.NUM(NUM), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NRD(NRD)) u_rf (
        .clk(clk), .rst_n(rst_n), .we_i(we_i), .waddr_i(wphys), .wdata_i(wdata_i),
        .raddr_i(rphys), .rdata_o(rdata_o)
    );

    assign rphys_o = rphys;

    // R9
    same_number_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (raddr_i[0] == waddr_i) |-> (rphys[0] == wphys));
endmodule

// File: rtl/rot_rename_unit.sv
// Top: general, floating-point and predicate rename classes side by side.
// Only the general window size is programmable; the other two are fixed.
module rot_rename_unit
    import rot_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gr_rot,
    input  logic              gr_size_we,
    input  logic [3:0]        gr_size_grp,
    input  logic              gr_we,
    input  logic [6:0]        gr_waddr,
    input  logic [DATA_W-1:0] gr_wdata,
    input  logic [6:0]        gr_raddr0,
    input  logic [6:0]        gr_raddr1,
    output logic [DATA_W-1:0] gr_rdata0,
    output logic [DATA_W-1:0] gr_rdata1,
    output logic [6:0]        gr_rphys0,
    output logic [6:0]        gr_rphys1,
    input  logic              fr_rot,
    input  logic              fr_we,
    input  logic [6:0]        fr_waddr,
    input  logic [DATA_W-1:0] fr_wdata,
    input  logic [6:0]        fr_raddr0,
    input  logic [6:0]        fr_raddr1,
    output logic [DATA_W-1:0] fr_rdata0,
    output logic [DATA_W-1:0] fr_rdata1,
    output logic [6:0]        fr_rphys0,
    output logic [6:0]        fr_rphys1,
    input  logic              pr_rot,
    input  logic              pr_we,
    input  logic [5:0]        pr_waddr,
    input  logic              pr_wdata,
    input  logic [5:0]        pr_raddr0,
    input  logic [5:0]        pr_raddr1,
    output logic              pr_rdata0,
    output logic              pr_rdata1,
    output logic [5:0]        pr_rphys0,
    output logic [5:0]        pr_rphys1
);
    logic [1:0][DATA_W-1:0] gr_rd, fr_rd;
    logic [1:0][6:0]        gr_ph, fr_ph;
    logic [1:0][0:0]        pr_rd;
    logic [1:0][5:0]        pr_ph;

    rot_class #(
        .NUM(GR_REGS), .BASE(GR_BASE), .MAX_ROT(GR_MAX), .RST_SIZE(0),
        .PROG(1'b1), .DATA_W(DATA_W), .GRAN(GRAN), .GRP_W(GRP_W)
    ) u_gr (
        .clk(clk), .rst_n(rst_n), .rot_i(gr_rot),
        .size_we_i(gr_size_we), .size_grp_i(gr_size_grp),
        .we_i(gr_we), .waddr_i(gr_waddr), .wdata_i(gr_wdata),
        .raddr_i({gr_raddr1, gr_raddr0}), .rdata_o(gr_rd), .rphys_o(gr_ph)
    );

    rot_class #(
        .NUM(FR_REGS), .BASE(FR_BASE), .MAX_ROT(FR_MAX), .RST_SIZE(FR_MAX),
        .PROG(1'b0), .DATA_W(DATA_W), .GRAN(GRAN), .GRP_W(GRP_W)
    ) u_fr (
        .clk(clk), .rst_n(rst_n), .rot_i(fr_rot),
        .size_we_i(1'b0), .size_grp_i('0),
        .we_i(fr_we), .waddr_i(fr_waddr), .wdata_i(fr_wdata),
        .raddr_i({fr_raddr1, fr_raddr0}), .rdata_o(fr_rd), .rphys_o(fr_ph)
    );

    rot_class #(
        .NUM(PR_REGS), .BASE(PR_BASE), .MAX_ROT(PR_MAX), .RST_SIZE(PR_MAX),
        .PROG(1'b0), .DATA_W(1), .GRAN(GRAN), .GRP_W(GRP_W)
    ) u_pr (
        .clk(clk), .rst_n(rst_n), .rot_i(pr_rot),
        .size_we_i(1'b0), .size_grp_i('0),
        .we_i(pr_we), .waddr_i(pr_waddr), .wdata_i(pr_wdata),
        .raddr_i({pr_raddr1, pr_raddr0}), .rdata_o(pr_rd), .rphys_o(pr_ph)
    );

    assign gr_rdata0 = gr_rd[0];
    assign gr_rdata1 = gr_rd[1];
    assign gr_rphys0 = gr_ph[0];
    assign gr_rphys1 = gr_ph[1];
    assign fr_rdata0 = fr_rd[0];
    assign fr_rdata1 = fr_rd[1];
    assign fr_rphys0 = fr_ph[0];
    assign fr_rphys1 = fr_ph[1];
    assign pr_rdata0 = pr_rd[0][0];
    assign pr_rdata1 = pr_rd[1][0];
    assign pr_rphys0 = pr_ph[0];
    assign pr_rphys1 = pr_ph[1];
endmodule

// File: tb/rot_rename_unit_tb_top.sv
module rot_rename_unit_tb_top;
    localparam int DW = 16;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n;
    logic          gr_rot, gr_size_we, gr_we;
    logic [3:0]    gr_size_grp;
    logic [6:0]    gr_waddr, gr_raddr0, gr_raddr1, gr_rphys0, gr_rphys1;
    logic [DW-1:0] gr_wdata, gr_rdata0, gr_rdata1;
    logic          fr_rot, fr_we;
    logic [6:0]    fr_waddr, fr_raddr0, fr_raddr1, fr_rphys0, fr_rphys1;
    logic [DW-1:0] fr_wdata, fr_rdata0, fr_rdata1;
    logic          pr_rot, pr_we, pr_wdata, pr_rdata0, pr_rdata1;
    logic [5:0]    pr_waddr, pr_raddr0, pr_raddr1, pr_rphys0, pr_rphys1;

    rot_rename_unit #(.DATA_W(DW)) dut_i (.*);

    int n_chk = 0;
    int n_bad = 0;

    // Vector fields: groups[25:22], rotations[21:14], logical[13:7], expected phys[6:0]
    localparam logic [25:0] VEC [11] = '{
        {4'd4,  8'd0, 7'd40,  7'd40},
        {4'd4,  8'd1, 7'd32,  7'd63},
        {4'd4,  8'd1, 7'd33,  7'd32},
        {4'd4,  8'd3, 7'd40,  7'd37},
        {4'd4,  8'd2, 7'd64,  7'd64},
        {4'd12, 8'd5, 7'd127, 7'd122},
        {4'd15, 8'd1, 7'd32,  7'd127},
        {4'd0,  8'd3, 7'd40,  7'd40},
        {4'd1,  8'd2, 7'd39,  7'd37},
        {4'd1,  8'd0, 7'd40,  7'd40},
        {4'd2,  8'd1, 7'd31,  7'd31}
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic settle();
        #2;
    endtask

    task automatic gr_size(input logic [3:0] g);
        gr_size_we = 1'b1; gr_size_grp = g;
        tick();
        gr_size_we = 1'b0;
    endtask

    task automatic gr_spin(input int n);
        for (int i = 0; i < n; i++) begin
            gr_rot = 1'b1;
            tick();
        end
        gr_rot = 1'b0;
    endtask

    task automatic gr_write(input logic [6:0] a, input logic [DW-1:0] d);
        gr_we = 1'b1; gr_waddr = a; gr_wdata = d;
        tick();
        gr_we = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        #(20 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog run did not finish actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        gr_rot = 0; gr_size_we = 0; gr_size_grp = 0; gr_we = 0; gr_waddr = 0; gr_wdata = 0;
        gr_raddr0 = 0; gr_raddr1 = 0;
        fr_rot = 0; fr_we = 0; fr_waddr = 0; fr_wdata = 0; fr_raddr0 = 0; fr_raddr1 = 0;
        pr_rot = 0; pr_we = 0; pr_waddr = 0; pr_wdata = 0; pr_raddr0 = 0; pr_raddr1 = 0;
        tick(); tick();
        rst_n = 1'b1;

        // R1 reset state
        gr_raddr0 = 7'd40; fr_raddr0 = 7'd32; pr_raddr0 = 6'd16; settle();
        chk("R1 gr phys 40", gr_rphys0, 40);
        chk("R1 gr data", gr_rdata0, 0);
        chk("R1 fr phys 32", fr_rphys0, 32);
        chk("R1 pr phys 16", pr_rphys0, 16);

        // R2 R5 R7 mapping vectors
        foreach (VEC[k]) begin
            gr_size(VEC[k][25:22]);
            gr_spin(int'(VEC[k][21:14]));
            gr_raddr0 = VEC[k][13:7]; settle();
            chk($sformatf("R2/R5 vector %0d", k), gr_rphys0, VEC[k][6:0]);
        end

        // R3 value at 35 moves to 36 then 37
        gr_size(4'd4);
        gr_write(7'd35, 16'hABCD);
        gr_spin(1);
        gr_raddr0 = 7'd36; settle();
        chk("R3 one rotation", gr_rdata0, 16'hABCD);
        gr_spin(1);
        gr_raddr0 = 7'd37; gr_raddr1 = 7'd35; settle();
        chk("R3 two rotations", gr_rdata0, 16'hABCD);
        chk("R3 old number empty", gr_rdata1, 0);

        // R4 top of window wraps to bottom
        gr_size(4'd1);
        gr_write(7'd39, 16'h1111);
        gr_spin(1);
        gr_raddr0 = 7'd32; settle();
        chk("R4 wrap", gr_rdata0, 16'h1111);

        // R9 write with same-cycle rotate
        gr_size(4'd4);
        gr_we = 1'b1; gr_waddr = 7'd34; gr_wdata = 16'h2222; gr_rot = 1'b1;
        tick();
        gr_we = 1'b0; gr_rot = 1'b0;
        gr_raddr0 = 7'd35; gr_raddr1 = 7'd34; settle();
        chk("R9 pre-rotation target", gr_rdata0, 16'h2222);
        chk("R9 not post-rotation target", gr_rdata1, 0);

        // R10 same-cycle read returns old value
        gr_size(4'd0);
        gr_we = 1'b1; gr_waddr = 7'd50; gr_wdata = 16'h5A5A; gr_raddr0 = 7'd50; settle();
        chk("R10 same cycle old", gr_rdata0, 0);
        tick();
        gr_we = 1'b0; settle();
        chk("R10 next cycle new", gr_rdata0, 16'h5A5A);

        // R7 size zero ignores rotation
        gr_write(7'd40, 16'h7777);
        gr_spin(2);
        gr_raddr0 = 7'd40; settle();
        chk("R7 data stays", gr_rdata0, 16'h7777);
        chk("R7 identity", gr_rphys0, 40);

        // R6 size load beats rotate
        gr_size(4'd4);
        gr_spin(3);
        gr_size_we = 1'b1; gr_size_grp = 4'd4; gr_rot = 1'b1;
        tick();
        gr_size_we = 1'b0; gr_rot = 1'b0;
        gr_raddr0 = 7'd32; settle();
        chk("R6 offset cleared", gr_rphys0, 32);

        // R11 low registers fixed
        gr_size(4'd12);
        gr_write(7'd5, 16'h0BEE);
        gr_spin(3);
        gr_raddr0 = 7'd5; settle();
        chk("R11 gr data", gr_rdata0, 16'h0BEE);
        chk("R11 gr phys", gr_rphys0, 5);

        // R8 class independence
        fr_raddr0 = 7'd40; pr_raddr0 = 6'd20; settle();
        chk("R8 fr untouched", fr_rphys0, 40);
        chk("R8 pr untouched", pr_rphys0, 20);

        fr_we = 1'b1; fr_waddr = 7'd32; fr_wdata = 16'h3C3C;
        tick();
        fr_we = 1'b0; fr_rot = 1'b1;
        tick();
        fr_rot = 1'b0;
        fr_raddr0 = 7'd33; fr_raddr1 = 7'd127; settle();
        chk("R8 fr moved", fr_rdata0, 16'h3C3C);
        chk("R8 fr phys 127", fr_rphys1, 126);
        fr_raddr1 = 7'd3; gr_raddr0 = 7'd32; settle();
        chk("R11 fr low fixed", fr_rphys1, 3);
        chk("R8 gr untouched by fr", gr_rphys0, 125);

        pr_we = 1'b1; pr_waddr = 6'd63; pr_wdata = 1'b1;
        tick();
        pr_we = 1'b0; pr_rot = 1'b1;
        tick();
        pr_rot = 1'b0;
        pr_raddr0 = 6'd16; pr_raddr1 = 6'd16; settle();
        chk("R4 pr wrap", pr_rdata0, 1);
        chk("R8 pr phys", pr_rphys1, 63);
        pr_rot = 1'b1;
        tick();
        pr_rot = 1'b0;
        pr_raddr0 = 6'd17; pr_raddr1 = 6'd15; settle();
        chk("R8 pr second rotation", pr_rdata0, 1);
        chk("R11 pr low fixed", pr_rphys1, 15);

        summary();
        $finish;
    end
endmodule